// File: doc/BRIEF.md
# Machine Timer Compare Interrupt

This block keeps a free-running elapsed-time count that is twice the register width, together with a compare value of the same width. The compare value is written as two register-width halves. When the timer is armed and the elapsed time has moved strictly past the compare value, the block raises a machine timer interrupt request.

A base `tick_i` pulse is divided by the `DIV` parameter, so the count moves at a fixed resolution. The timer is checked only on an `step_i` strobe, which the core gives once per instruction step, before fetch. Writing either compare half re-arms the timer. Once armed, the timer fires a single request and then disarms until the next compare write.

The request leaves on a valid/ready interface. `irq_valid` and its payload stay constant until the trap logic accepts the request, which happens on a cycle where `irq_valid` and `irq_ready` are both high. No further request can be produced while one is waiting. A compare write drops any request still waiting, because the new compare value makes it stale. Deciding when to enter the trap, and how this request ranks against other causes, is left to the consumer.

Top module: `mtimer_irq`

## Requirements
- R1: Reset state. After reset the time count is 0, both compare halves are 0, the timer is disarmed and `irq_valid` is 0. A step with no compare write since reset raises no request.
- R2: The time count goes up by exactly one after every `DIV` clock cycles that have `tick_i` high. The ticks need not be consecutive. The count never changes on any other cycle.
- R3: `time_lo_o` carries bits [XLEN-1:0] of the time count. `time_hi_o` carries bits [2*XLEN-1:XLEN].
- R4: A write with `csr_sel`=0 replaces only the low compare half. A write with `csr_sel`=1 replaces only the high compare half. The compare value is {high, low}.
- R5: Any compare write arms the timer, and `irq_valid` is 0 on the following cycle.
- R6: On a cycle with `step_i` high and the timer armed, a compare value strictly less than the time count sets `irq_valid` on the next cycle. The payload is then `irq_is_int`=1, `irq_cause`=7 and `irq_tval`=0.
- R7: A step where the compare value equals or exceeds the time count raises no request.
- R8: Raising a request disarms the timer. Later steps raise nothing until the next compare write.
- R9: `irq_valid` and its payload hold steady until a cycle with `irq_ready` high. `irq_valid` is 0 on the cycle after that.
- R10: An armed, expired timer raises no request while `step_i` stays low.
- R11: When a compare write and a step fall on the same cycle, the write wins. No request comes from that step, and the timer is left armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base time tick, divided by DIV |
| step_i | input | 1 | Instruction step strobe that triggers the timer check |
| csr_we | input | 1 | Compare half write enable |
| csr_sel | input | 1 | Compare half select: 0 low, 1 high |
| csr_wdata | input | XLEN | Compare half write data |
| time_lo_o | output | XLEN | Low word of the time count |
| time_hi_o | output | XLEN | High word of the time count |
| irq_valid | output | 1 | Interrupt request valid |
| irq_ready | input | 1 | Trap logic accepts the request |
| irq_is_int | output | 1 | Interrupt flag of the request |
| irq_cause | output | 5 | Cause code of the request |
| irq_tval | output | XLEN | Trap value of the request |

## Verification
The bound checker checks these on every cycle: the time word only ever moves by one, a request appears only right after a step, a waiting request and its payload hold under back-pressure, and a compare write leaves no request behind.

Some behaviours depend on arithmetic, so only the bench scenarios can show them. These are the strict less-than boundary against equal values, the rebuilding of the compare value from one half while the other is retained, the one-shot disarm, and the tie between a write and a step in the same cycle. The bench checks these with a small width of eight bits per half, and sweeps the compare value around every time value while the count crosses the half boundary.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MACH_TIMER = 5'd7;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } cmp_half_e;
endpackage

// File: rtl/mtimer_prescale.sv
module mtimer_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic adv_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      logic unused_pass;
      assign unused_pass = &{1'b0, clk, rst_n};
      assign adv_o = tick_i;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          last;
      assign last  = (cnt_q == CW'(DIV - 1));
      assign adv_o = tick_i && last;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (tick_i) begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mtimer_count.sv
module mtimer_count #(
  parameter int unsigned TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [TW-1:0] time_o
);
  logic [TW-1:0] time_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (adv_i) begin
      time_q <= time_q + 1'b1;
    end
  end

  assign time_o = time_q;
endmodule

// File: rtl/mtimer_cmpreg.sv
module mtimer_cmpreg
  import mtimer_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned TW = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  cmp_half_e       wr_half,
  input  logic [XLEN-1:0] wr_data,
  output logic [TW-1:0]   cmp_o
);
  logic [XLEN-1:0] half_q [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        half_q[h] <= '0;
      end else if (wr_en && (int'(wr_half) == h)) begin
        half_q[h] <= wr_data;
      end
    end
  end

  assign cmp_o = {half_q[1], half_q[0]};
endmodule

// File: rtl/mtimer_arm.sv
module mtimer_arm
  import mtimer_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned TW = 2 * XLEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               step_i,
  input  logic [TW-1:0]      cmp_i,
  input  logic [TW-1:0]      time_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic               is_int_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    tval_o
);
  logic armed_q;
  logic valid_q;
  logic expired;
  logic fire;

  assign expired = (cmp_i < time_i);
  assign fire    = armed_q && step_i && expired && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      valid_q  <= 1'b0;
      is_int_o <= 1'b0;
      cause_o  <= '0;
      tval_o   <= '0;
    end else if (wr_en) begin
      armed_q  <= 1'b1;
      valid_q  <= 1'b0;
      is_int_o <= 1'b0;
      cause_o  <= '0;
      tval_o   <= '0;
    end else if (fire) begin
      armed_q  <= 1'b0;
      valid_q  <= 1'b1;
      is_int_o <= 1'b1;
      cause_o  <= CAUSE_MACH_TIMER;
      tval_o   <= '0;
    end else if (valid_q && ready_i) begin
      valid_q  <= 1'b0;
      is_int_o <= 1'b0;
      cause_o  <= '0;
      tval_o   <= '0;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/mtimer_irq.sv
module mtimer_irq
  import mtimer_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned DIV  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               step_i,
  input  logic               csr_we,
  input  logic               csr_sel,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    time_lo_o,
  output logic [XLEN-1:0]    time_hi_o,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic               irq_is_int,
  output logic [CAUSE_W-1:0] irq_cause,
  output logic [XLEN-1:0]    irq_tval
);
  localparam int unsigned TW = 2 * XLEN;

  logic          adv;
  logic [TW-1:0] time_w;
  logic [TW-1:0] cmp_w;

  mtimer_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .adv_o(adv)
  );

  mtimer_count #(.TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .time_o(time_w)
  );

  mtimer_cmpreg #(.XLEN(XLEN)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_we),
    .wr_half(cmp_half_e'(csr_sel)), .wr_data(csr_wdata), .cmp_o(cmp_w)
  );

  mtimer_arm #(.XLEN(XLEN)) u_arm (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_we), .step_i(step_i),
    .cmp_i(cmp_w), .time_i(time_w), .ready_i(irq_ready),
    .valid_o(irq_valid), .is_int_o(irq_is_int), .cause_o(irq_cause),
    .tval_o(irq_tval)
  );

  assign time_lo_o = time_w[XLEN-1:0];
  assign time_hi_o = time_w[TW-1:XLEN];
endmodule

// File: rtl/mtimer_irq_chk.sv
module mtimer_irq_chk
  import mtimer_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step_i,
  input logic               csr_we,
  input logic [XLEN-1:0]    time_lo_o,
  input logic [XLEN-1:0]    time_hi_o,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic               irq_is_int,
  input logic [CAUSE_W-1:0] irq_cause,
  input logic [XLEN-1:0]    irq_tval
);
  logic [2*XLEN-1:0] t_all;
  assign t_all = {time_hi_o, time_lo_o};

  p_time_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(t_all) |-> (t_all == $past(t_all) + 1'b1));

  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> !irq_valid);

  p_rise_after_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> ($past(step_i) && !$past(csr_we)));

  p_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_is_int && irq_cause == 5'd7 && irq_tval == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !csr_we) |=>
      (irq_valid && $stable(irq_cause) && $stable(irq_is_int) && $stable(irq_tval)));

  p_accept_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !irq_valid);
endmodule

bind mtimer_irq mtimer_irq_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .csr_we(csr_we),
  .time_lo_o(time_lo_o), .time_hi_o(time_hi_o), .irq_valid(irq_valid),
  .irq_ready(irq_ready), .irq_is_int(irq_is_int), .irq_cause(irq_cause),
  .irq_tval(irq_tval)
);

// File: tb/mtimer_irq_bench.sv
module mtimer_irq_bench;
  localparam int unsigned XLEN = 8;
  localparam int unsigned DIV  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tick_i = 1'b0, step_i = 1'b0, csr_we = 1'b0, csr_sel = 1'b0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic            irq_ready = 1'b0;
  logic [XLEN-1:0] time_lo_o, time_hi_o, irq_tval;
  logic            irq_valid, irq_is_int;
  logic [4:0]      irq_cause;

  int errors = 0;
  int checks = 0;
  int ticks  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mtimer_irq #(.XLEN(XLEN), .DIV(DIV)) u_mtimer_irq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .step_i(step_i),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .time_lo_o(time_lo_o), .time_hi_o(time_hi_o), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_is_int(irq_is_int), .irq_cause(irq_cause),
    .irq_tval(irq_tval)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus, entered and left at a falling edge
  task automatic cyc(input bit tk, input bit we, input bit sel,
                     input int data, input bit st, input bit rdy);
    tick_i = tk; csr_we = we; csr_sel = sel;
    csr_wdata = XLEN'(data); step_i = st; irq_ready = rdy;
    @(negedge clk);
    if (tk) ticks++;
    tick_i = 0; csr_we = 0; step_i = 0; irq_ready = 0;
  endtask

  task automatic set_cmp(input int c);
    cyc(0, 1, 1, (c >> XLEN) & 255, 0, 0);
    cyc(0, 1, 0, c & 255, 0, 0);
  endtask

  task automatic chk_time(input string req);
    chk(req, int'({time_hi_o, time_lo_o}), ticks / DIV);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", int'({time_hi_o, time_lo_o}), 0);
    chk("R1 valid", int'(irq_valid), 0);
    // R2 ticks with gaps
    for (int i = 0; i < 15; i++) begin
      cyc(1, 0, 0, 0, 0, 0);
      if (i % 2 == 0) cyc(0, 0, 0, 0, 0, 0);
      chk_time("R2 gap ticks");
    end
    // R1 disarmed after reset, compare 0 < time 5
    cyc(0, 0, 0, 0, 1, 0);
    chk("R1 no arm after reset", int'(irq_valid), 0);

    // sweep across the low-half boundary
    for (int t = 5; t < 600; t++) begin
      while (ticks / DIV < t) begin
        cyc(1, 0, 0, 0, 0, 0);
        chk_time("R2 count");
      end
      chk("R3 lo", int'(time_lo_o), t & 255);
      chk("R3 hi", int'(time_hi_o), t >> 8);
      set_cmp(t);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R7 equal", int'(irq_valid), 0);
      set_cmp(t + 1);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R7 greater", int'(irq_valid), 0);
      set_cmp(t - 1);
      chk("R5 armed no pending", int'(irq_valid), 0);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R6 valid", int'(irq_valid), 1);
      chk("R6 is_int", int'(irq_is_int), 1);
      chk("R6 cause", int'(irq_cause), 7);
      chk("R6 tval", int'(irq_tval), 0);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R9 held", int'(irq_valid), 1);
      chk("R9 cause held", int'(irq_cause), 7);
      cyc(0, 0, 0, 0, 0, 1);
      chk("R9 accepted", int'(irq_valid), 0);
      cyc(0, 0, 0, 0, 1, 0);
      chk("R8 one shot", int'(irq_valid), 0);
    end

    // time is now 599 = 0x257
    chk_time("R2 final");
    // R4 half retention
    set_cmp(0);
    cyc(0, 1, 1, 5, 0, 0);          // compare 0x0500
    cyc(0, 0, 0, 0, 1, 0);
    chk("R4 high only", int'(irq_valid), 0);
    cyc(0, 1, 0, 255, 0, 0);        // compare 0x05FF
    cyc(0, 1, 1, 2, 0, 0);          // compare 0x02FF
    cyc(0, 0, 0, 0, 1, 0);
    chk("R4 low kept", int'(irq_valid), 0);
    cyc(0, 1, 0, 'h56, 0, 0);       // compare 0x0256 < 0x0257
    cyc(0, 0, 0, 0, 1, 0);
    chk("R4 rebuilt", int'(irq_valid), 1);
    cyc(0, 0, 0, 0, 0, 1);
    // R10 no step, no request
    set_cmp(0);
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 0, 0, 0, 0);
      chk("R10 idle", int'(irq_valid), 0);
    end
    // R11 write and step together
    cyc(0, 1, 0, 0, 1, 0);
    chk("R11 write wins", int'(irq_valid), 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R11 still armed", int'(irq_valid), 1);
    // R5 write drops pending request
    cyc(0, 1, 1, 0, 0, 0);
    chk("R5 stale dropped", int'(irq_valid), 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R5 rearmed", int'(irq_valid), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule